// File: doc/BRIEF.md
# ADC Result Accumulation and Decimation Unit

This block sits behind a fixed-width converter core and turns its stream of raw samples into one final result word. Each accepted sample is added into a wide accumulator. When the number of samples that the selected mode needs has been collected, the sum is shifted right, clamped to the width of the mode, optionally moved to the top of the 16-bit word, and written to the result register. A result-ready flag is raised at the same moment.

One datapath serves three families of modes. The plain modes (12, 10 and 8 bits) take a single sample and drop its low bits. The oversampling modes (13 to 16 bits) gain n extra bits by summing 4^n samples and shifting the sum right by n. The custom averaging mode sums 2^a samples and then shifts the sum right by an independent amount k. Reading the result clears the flags. A result that replaces an unread one raises an overrun flag. A start pulse throws away a partial accumulation.

Top module: `adc_accum_dec`

## Requirements
- R1: After reset, `result_o` is 0 and `ready_o` and `overrun_o` are both low.
- R2: `res_sel_i` encodes the mode as follows: 0 is 12-bit, 1 is 10-bit, 2 is 8-bit, 3 to 6 are 13 to 16 bits, and 7 is custom. In the 12-, 10- and 8-bit modes each sample alone forms a result, equal to the sample shifted right by 0, 2 or 4. In every mode other than custom, a result without left adjustment has no bit set at or above the mode's width.
- R3: In oversampling mode `res_sel_i = 2+n` (n = 1 to 4), a result is the sum of 4^n consecutive samples shifted right by n, and is 12+n bits wide.
- R4: In custom mode a result sums 2^a samples, where a = `avg_log2_i`. Values of `avg_log2_i` above 10 are treated as 10, which gives 1024 samples.
- R5: In custom mode the sum is shifted right by k = `div_shift_i` (0 to 7). Any value above 0xFFFF saturates to 0xFFFF. The accumulator never wraps.
- R6: When `left_adj_i` is high, the result is shifted left by 16 minus the mode width, so its low bits are zero. In custom mode the width is 16, so left adjustment has no effect.
- R7: `result_o` and `ready_o` change on the clock edge that accepts the final sample of an accumulation. `ready_o` stays low while that accumulation is still short of its count.
- R8: A `rd_i` pulse in a cycle with no new result clears both `ready_o` and `overrun_o`.
- R9: If a new result is written while `ready_o` is high and `rd_i` is low, `overrun_o` is set. It then stays set until a read. A new result that coincides with `rd_i` leaves `ready_o` high and `overrun_o` low.
- R10: `start_i` clears the partial sum and the sample count. A sample accepted in the same cycle becomes the first sample of the new accumulation.
- R11: Cycles with `smp_valid_i` low do not change the accumulation or the result, whatever is on `smp_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_sel_i | input | 3 | Resolution or mode select |
| avg_log2_i | input | 4 | Custom mode: log2 of sample count |
| div_shift_i | input | 3 | Custom mode: right shift of the sum |
| left_adj_i | input | 1 | Left-adjust the result |
| start_i | input | 1 | Restart accumulation |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 12 | Raw sample |
| rd_i | input | 1 | Result read pulse |
| result_o | output | 16 | Result register |
| ready_o | output | 1 | Result-ready flag |
| overrun_o | output | 1 | Unread result overwritten |

## Verification
On every cycle, the assertions check the flag protocol: overrun only rises while a result is pending, it is sticky until a read, a read clears both flags, and the result holds between writes. They also check that the adder never wraps, that an unadjusted value fits its width, and that a left-adjusted value has its low bit clear. The bench scenarios are what show the arithmetic. This covers the sample counts per mode, the shift and saturation values, the clamp of the averaging count, the restart semantics, and the exact edge on which a result appears.

// File: rtl/adc_acc_pkg.sv
package adc_acc_pkg;
  localparam int DIV_W = 3;
  localparam int SH_W  = 3;

  typedef enum logic [2:0] {
    SEL_12     = 3'd0,
    SEL_10     = 3'd1,
    SEL_8      = 3'd2,
    SEL_13     = 3'd3,
    SEL_14     = 3'd4,
    SEL_15     = 3'd5,
    SEL_16     = 3'd6,
    SEL_CUSTOM = 3'd7
  } res_sel_e;
endpackage

// File: rtl/acd_mode_dec.sv
module acd_mode_dec
  import adc_acc_pkg::*;
#(
  parameter int SMP_W    = 12,
  parameter int MAX_LOG2 = 10,
  parameter int RES_W    = 16,
  parameter int LOG_W    = 4,
  parameter int WID_W    = 5
) (
  input  logic [2:0]       res_sel_i,
  input  logic [LOG_W-1:0] avg_log2_i,
  input  logic [DIV_W-1:0] div_shift_i,
  output logic [LOG_W-1:0] log2_cnt_o,
  output logic [SH_W-1:0]  shift_o,
  output logic [WID_W-1:0] width_o
);
  res_sel_e   sel;
  logic [2:0] os_n;

  assign sel  = res_sel_e'(res_sel_i);
  assign os_n = res_sel_i - 3'd2;

  always_comb begin
    log2_cnt_o = '0;
    shift_o    = '0;
    width_o    = WID_W'(SMP_W);
    unique case (sel)
      SEL_12: ;
      SEL_10: begin
        shift_o = SH_W'(2);
        width_o = WID_W'(SMP_W - 2);
      end
      SEL_8: begin
        shift_o = SH_W'(4);
        width_o = WID_W'(SMP_W - 4);
      end
      SEL_13, SEL_14, SEL_15, SEL_16: begin
        log2_cnt_o = LOG_W'({os_n, 1'b0});
        shift_o    = SH_W'(os_n);
        width_o    = WID_W'(SMP_W) + WID_W'(os_n);
      end
      SEL_CUSTOM: begin
        log2_cnt_o = (avg_log2_i > LOG_W'(MAX_LOG2)) ? LOG_W'(MAX_LOG2) : avg_log2_i;
        shift_o    = SH_W'(div_shift_i);
        width_o    = WID_W'(RES_W);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acd_seq_ctrl.sv
module acd_seq_ctrl #(
  parameter int CNT_W = 10,
  parameter int LOG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic [LOG_W-1:0] log2_cnt_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_base, target;
  logic [CNT_W:0]   span;

  assign span     = ({{CNT_W{1'b0}}, 1'b1} << log2_cnt_i) - 1'b1;
  assign target   = span[CNT_W-1:0];
  assign cnt_base = start_i ? '0 : cnt_q;
  // >= keeps the counter from running away if the mode shrinks mid-run
  assign last_o   = valid_i && (cnt_base >= target);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (valid_i) cnt_q <= last_o ? '0 : cnt_base + 1'b1;
    else if (start_i) cnt_q <= '0;
  end

  assert_cnt_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !valid_i) |=> (cnt_q == '0));
endmodule

// File: rtl/acd_accum.sv
module acd_accum #(
  parameter int SMP_W = 12,
  parameter int ACC_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic             last_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic [ACC_W-1:0] sum_o
);
  logic [ACC_W-1:0] acc_q, acc_base;

  assign acc_base = start_i ? '0 : acc_q;
  assign sum_o    = acc_base + ACC_W'(smp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (valid_i) acc_q <= last_i ? '0 : sum_o;
    else if (start_i) acc_q <= '0;
  end

  assert_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !start_i) |-> (sum_o >= acc_q));

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !start_i) |=> $stable(acc_q));
endmodule

// File: rtl/acd_shaper.sv
module acd_shaper
  import adc_acc_pkg::*;
#(
  parameter int ACC_W = 22,
  parameter int RES_W = 16,
  parameter int WID_W = 5
) (
  input  logic [ACC_W-1:0] sum_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic [WID_W-1:0] width_i,
  input  logic             left_adj_i,
  output logic [RES_W-1:0] value_o
);
  logic [ACC_W-1:0] shifted;
  logic [RES_W-1:0] clamped;

  assign shifted = sum_i >> shift_i;

  generate
    if (ACC_W > RES_W) begin : g_sat
      logic [ACC_W-1:0] max_val;
      assign max_val = (ACC_W'(1) << width_i) - ACC_W'(1);
      assign clamped = (shifted > max_val) ? max_val[RES_W-1:0] : shifted[RES_W-1:0];
    end else begin : g_nosat
      assign clamped = RES_W'(shifted);
    end
  endgenerate

  assign value_o = left_adj_i ? (clamped << (WID_W'(RES_W) - width_i)) : clamped;
endmodule

// File: rtl/acd_flags.sv
module acd_flags #(
  parameter int RES_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [RES_W-1:0] value_i,
  output logic [RES_W-1:0] result_o,
  output logic             ready_o,
  output logic             overrun_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      ready_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else if (wr_i) begin
      result_o  <= value_i;
      ready_o   <= 1'b1;
      if (rd_i)         overrun_o <= 1'b0;
      else if (ready_o) overrun_o <= 1'b1;
    end else if (rd_i) begin
      ready_o   <= 1'b0;
      overrun_o <= 1'b0;
    end
  end

  assert_ovr_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(ready_o));

  assert_ovr_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !rd_i) |=> overrun_o);

  assert_rd_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> (!ready_o && !overrun_o));

  assert_result_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(result_o));
endmodule

// File: rtl/adc_accum_dec.sv
module adc_accum_dec
  import adc_acc_pkg::*;
#(
  parameter int SMP_W    = 12,
  parameter int MAX_LOG2 = 10,
  parameter int RES_W    = 16,
  localparam int LOG_W   = $clog2(MAX_LOG2 + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       res_sel_i,
  input  logic [LOG_W-1:0] avg_log2_i,
  input  logic [DIV_W-1:0] div_shift_i,
  input  logic             left_adj_i,
  input  logic             start_i,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_data_i,
  input  logic             rd_i,
  output logic [RES_W-1:0] result_o,
  output logic             ready_o,
  output logic             overrun_o
);
  localparam int ACC_W = SMP_W + MAX_LOG2;
  localparam int CNT_W = MAX_LOG2;
  localparam int WID_W = $clog2(RES_W + 1);

  logic [LOG_W-1:0] log2_cnt;
  logic [SH_W-1:0]  shift;
  logic [WID_W-1:0] width;
  logic             last;
  logic [ACC_W-1:0] sum;
  logic [RES_W-1:0] shaped;

  acd_mode_dec #(.SMP_W(SMP_W), .MAX_LOG2(MAX_LOG2), .RES_W(RES_W),
                 .LOG_W(LOG_W), .WID_W(WID_W)) u_dec (
    .res_sel_i   (res_sel_i),
    .avg_log2_i  (avg_log2_i),
    .div_shift_i (div_shift_i),
    .log2_cnt_o  (log2_cnt),
    .shift_o     (shift),
    .width_o     (width)
  );

  acd_seq_ctrl #(.CNT_W(CNT_W), .LOG_W(LOG_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .valid_i    (smp_valid_i),
    .log2_cnt_i (log2_cnt),
    .last_o     (last)
  );

  acd_accum #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .valid_i (smp_valid_i),
    .last_i  (last),
    .smp_i   (smp_data_i),
    .sum_o   (sum)
  );

  acd_shaper #(.ACC_W(ACC_W), .RES_W(RES_W), .WID_W(WID_W)) u_shp (
    .sum_i      (sum),
    .shift_i    (shift),
    .width_i    (width),
    .left_adj_i (left_adj_i),
    .value_o    (shaped)
  );

  acd_flags #(.RES_W(RES_W)) u_flg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (last),
    .rd_i      (rd_i),
    .value_i   (shaped),
    .result_o  (result_o),
    .ready_o   (ready_o),
    .overrun_o (overrun_o)
  );

  assert_width_fit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && !left_adj_i) |-> ((shaped >> width) == '0));

  assert_left_low_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && left_adj_i && (width < WID_W'(RES_W))) |-> (shaped[0] == 1'b0));
endmodule

// File: tb/sim_adc_accum_dec.sv
module sim_adc_accum_dec;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  sel = '0;
  logic [3:0]  avg = '0;
  logic [2:0]  dsh = '0;
  logic        la = 1'b0;
  logic        start = 1'b0;
  logic        valid = 1'b0;
  logic [11:0] data = '0;
  logic        rd = 1'b0;
  logic [15:0] result;
  logic        ready, overrun;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_accum_dec u0 (
    .clk_i(clk), .rst_ni(rst_n), .res_sel_i(sel), .avg_log2_i(avg),
    .div_shift_i(dsh), .left_adj_i(la), .start_i(start),
    .smp_valid_i(valid), .smp_data_i(data), .rd_i(rd),
    .result_o(result), .ready_o(ready), .overrun_o(overrun)
  );

  task automatic check(input string req, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic int nsamp(input int s, input int a);
    if (s <= 2) return 1;
    if (s <= 6) return 1 << (2 * (s - 2));
    return 1 << ((a > 10) ? 10 : a);
  endfunction

  function automatic longint expv(input int s, input int k, input bit l, input longint sum);
    int sh, w;
    longint v;
    case (s)
      0: begin sh = 0; w = 12; end
      1: begin sh = 2; w = 10; end
      2: begin sh = 4; w = 8; end
      7: begin sh = k; w = 16; end
      default: begin sh = s - 2; w = 10 + s; end
    endcase
    v = sum >> sh;
    if (v > (64'd1 << w) - 1) v = (64'd1 << w) - 1;
    if (l) v = v << (16 - w);
    return v & 64'hFFFF;
  endfunction

  task automatic put(input logic [11:0] d, input bit st);
    valid = 1'b1; data = d; start = st;
    @(negedge clk);
    valid = 1'b0; start = 1'b0; data = 12'($urandom);
  endtask

  task automatic do_read();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  // pattern: 0 random, 1 full scale, 2 zero
  task automatic run_acc(input int s, input int a, input int k, input bit l,
                         input int pat, input bit gaps, input string req);
    int n;
    longint sum;
    logic [11:0] d;
    sel = 3'(s); avg = 4'(a); dsh = 3'(k); la = l;
    n = nsamp(s, a);
    sum = 0;
    for (int i = 0; i < n; i++) begin
      d = (pat == 1) ? 12'hFFF : (pat == 2) ? 12'h000 : 12'($urandom);
      sum += d;
      put(d, 1'b0);
      if (gaps && (i % 3 == 0)) @(negedge clk);
      if (i == n - 2) check("R7 ready early", ready, 0);
    end
    check(req, result, expv(s, k, l, sum));
    check("R7 ready", ready, 1);
    do_read();
    check("R8 ready cleared", ready, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check("R1 result", result, 0);
    check("R1 ready", ready, 0);
    check("R1 overrun", overrun, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 plain and R3 oversampling, both alignments
    for (int s = 0; s <= 6; s++) begin
      run_acc(s, 0, 0, 1'b0, 0, s[0], (s <= 2) ? "R2 plain" : "R3 oversample");
      run_acc(s, 0, 0, 1'b1, 0, 1'b0, "R6 left adjust");
    end
    run_acc(0, 0, 0, 1'b0, 1, 1'b0, "R2 12-bit full scale");
    run_acc(2, 0, 0, 1'b1, 1, 1'b0, "R6 8-bit left full scale");
    run_acc(6, 0, 0, 1'b0, 1, 1'b0, "R3 16-bit full scale");
    run_acc(5, 0, 0, 1'b1, 1, 1'b0, "R6 15-bit left full scale");

    // R4 and R5 custom averaging
    run_acc(7, 0, 0, 1'b0, 0, 1'b0, "R4 custom 1 sample");
    run_acc(7, 3, 3, 1'b0, 0, 1'b1, "R5 custom 8 by 8");
    run_acc(7, 5, 2, 1'b0, 0, 1'b0, "R5 custom 32 by 4");
    run_acc(7, 4, 0, 1'b1, 0, 1'b0, "R6 custom left no effect");
    run_acc(7, 10, 0, 1'b0, 1, 1'b0, "R5 saturate 0xFFFF");
    run_acc(7, 10, 7, 1'b0, 1, 1'b0, "R5 1024 by 128");
    run_acc(7, 12, 7, 1'b0, 0, 1'b0, "R4 clamp to 1024");
    run_acc(7, 1, 0, 1'b0, 2, 1'b0, "R4 zero input");

    // R9 overrun then R8 read clears both
    sel = 3'd0; la = 1'b0;
    put(12'h123, 1'b0);
    put(12'h456, 1'b0);
    check("R9 result latest", result, 16'h0456);
    check("R9 ready", ready, 1);
    check("R9 overrun set", overrun, 1);
    @(negedge clk);
    check("R9 overrun sticky", overrun, 1);
    do_read();
    check("R8 ready clear", ready, 0);
    check("R8 overrun clear", overrun, 0);

    // R9 write coinciding with read
    put(12'h0AA, 1'b0);
    rd = 1'b1;
    put(12'h0BB, 1'b0);
    rd = 1'b0;
    check("R9 coincident ready", ready, 1);
    check("R9 coincident overrun", overrun, 0);
    check("R9 coincident result", result, 16'h00BB);
    do_read();

    // R10 restart mid accumulation: 13-bit mode, 4 samples
    sel = 3'd3;
    put(12'hFFF, 1'b0);
    put(12'hFFF, 1'b0);
    put(12'h010, 1'b1);
    put(12'h020, 1'b0);
    check("R10 not ready yet", ready, 0);
    put(12'h030, 1'b0);
    put(12'h040, 1'b0);
    check("R10 restart sum", result, 16'h0050);
    check("R10 ready", ready, 1);
    do_read();

    // R10 start alone clears partial sum
    put(12'h700, 1'b0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    for (int i = 0; i < 4; i++) put(12'h002, 1'b0);
    check("R10 start alone", result, 16'h0004);
    do_read();

    // R11 idle cycles with garbage data change nothing
    sel = 3'd0;
    put(12'h321, 1'b0);
    for (int i = 0; i < 5; i++) begin
      data = 12'($urandom);
      @(negedge clk);
    end
    check("R11 result held", result, 16'h0321);
    check("R11 ready held", ready, 1);
    do_read();
    sel = 3'd4;
    for (int i = 0; i < 15; i++) put(12'h001, 1'b0);
    for (int i = 0; i < 4; i++) begin
      data = 12'hFFF;
      @(negedge clk);
    end
    check("R11 no sample taken", ready, 0);
    put(12'h011, 1'b0);
    check("R11 sum after idle", result, 16'h0008);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule